// File: doc/BRIEF.md
# Sixteen-bit host bridge to a 32-bit IDE register port

This block sits between a host with a 16-bit data bus and an IDE controller whose register windows are 32 bits wide. The host gives a halfword offset, a write flag, 16 bits of data and a 2-bit byte mask. The bridge works out which controller window the offset falls in: configuration, command block or control block. It places data and byte mask on the correct half of the 32-bit word and issues one downstream access. On a read it returns the matching half of the answer.

A second host window, chosen by `h_win32`, lets the host fetch the 32-bit data port in two steps. A read at the first halfword of the command block performs a full 32-bit data read and returns the low half. The high half is kept in a 16-bit holding latch. A read at the next halfword returns the latch without touching the controller. Addresses that map to nothing return all ones on read and are dropped on write. The controller is expected to answer a read on `d_rdata` in the same cycle as `d_stb`.

Top module: `ide_halfword_bridge`

## Requirements
- R1: In the 16-bit window (`h_win32`=0), the byte offset is twice `h_addr`. Byte offsets 0x30..0x3F select the configuration window (`d_sel`=0), 0x1F0..0x1F7 the command block (`d_sel`=1) and 0x3F0..0x3F7 the control block (`d_sel`=2).
- R2: Bit 0 of `h_addr` picks the lane. When it is 1, write data goes on `d_wdata[31:16]`, the byte mask on `d_be[3:2]`, and the read returns `d_rdata[31:16]`; the other half of `d_wdata` and `d_be` is zero. When it is 0, the low halves are used the same way.
- R3: `d_idx` is `h_addr[2:1]` (halfword offset / 2 mod 4) for the configuration window, and `{0, h_addr[1]}` (halfword offset / 2 mod 2) for both blocks.
- R4: In the 16-bit window, a read of an unmapped offset returns 0xFFFF and a write to one is dropped; neither raises `d_stb`.
- R5: In the 32-bit window, a read at byte offset 0x1F0 (`h_addr`=0xF8) raises `d_stb` with `d_sel`=1, `d_idx`=0, `d_we`=0 and `d_be`=0xF. It returns `d_rdata[15:0]` and stores `d_rdata[31:16]` in the holding latch.
- R6: In the 32-bit window, a read at byte offset 0x1F2 (`h_addr`=0xF9) returns the latch with no downstream access. Any other read there returns 0xFFFF with no downstream access.
- R7: Every write in the 32-bit window is ignored: no `d_stb`, no `h_rvalid`, and the latch is unchanged.
- R8: The latch is zero after reset. It changes only on a 32-bit-window read at byte offset 0x1F0.
- R9: `d_stb` is high only in a cycle with `h_req` high, for exactly that cycle. For every host read, `h_rvalid` is high with `h_rdata` valid in the next cycle. A write produces no `h_rvalid`. After reset, `h_rvalid` and `h_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, one per cycle |
| h_win32 | input | 1 | 1 selects the split 32-bit data window |
| h_we | input | 1 | 1 for write, 0 for read |
| h_addr | input | HADDR_W | Halfword offset inside the host window |
| h_wdata | input | HALF_W | Host write data |
| h_be | input | HALF_W/8 | Host byte mask |
| h_rvalid | output | 1 | Read data valid, one cycle after a read request |
| h_rdata | output | HALF_W | Registered read data |
| d_stb | output | 1 | Downstream access strobe |
| d_we | output | 1 | Downstream write flag |
| d_sel | output | 2 | Target window: 0 configuration, 1 command block, 2 control block |
| d_idx | output | 2 | 32-bit word index inside the target window |
| d_wdata | output | 2*HALF_W | Lane-shifted write data |
| d_be | output | HALF_W/4 | Lane-shifted byte mask |
| d_rdata | input | 2*HALF_W | Controller read data, valid in the strobe cycle |

## Verification
The downstream outputs are combinational from the host request, so the bench drives a request on a falling edge and reads `d_stb`, `d_sel`, `d_idx`, `d_wdata` and `d_be` one time unit later, inside the same cycle. `h_rvalid` and `h_rdata` pass through one register, so they are sampled on the following falling edge, one cycle after the request. The holding latch has no port of its own. It is checked by a later 32-bit-window read at byte offset 0x1F2, which returns it one cycle after that read, even after writes and other traffic have gone by in between.

// File: rtl/ide_halfword_bridge.sv
module ide_halfword_bridge #(
  parameter int HADDR_W  = 11,
  parameter int HALF_W   = 16,
  parameter int CFG_BASE = 'h030,
  parameter int CFG_SPAN = 'h10,
  parameter int CS0_BASE = 'h1F0,
  parameter int CS1_BASE = 'h3F0,
  parameter int BLK_SPAN = 'h8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  h_req,
  input  logic                  h_win32,
  input  logic                  h_we,
  input  logic [HADDR_W-1:0]    h_addr,
  input  logic [HALF_W-1:0]     h_wdata,
  input  logic [HALF_W/8-1:0]   h_be,
  output logic                  h_rvalid,
  output logic [HALF_W-1:0]     h_rdata,
  output logic                  d_stb,
  output logic                  d_we,
  output logic [1:0]            d_sel,
  output logic [1:0]            d_idx,
  output logic [2*HALF_W-1:0]   d_wdata,
  output logic [HALF_W/4-1:0]   d_be,
  input  logic [2*HALF_W-1:0]   d_rdata
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int HBE_W  = HALF_W / 8;
  localparam int OFF_W  = HADDR_W + 1;

  localparam logic [OFF_W-1:0] CFG_LO = OFF_W'(CFG_BASE);
  localparam logic [OFF_W-1:0] CFG_HI = OFF_W'(CFG_BASE + CFG_SPAN);
  localparam logic [OFF_W-1:0] CS0_LO = OFF_W'(CS0_BASE);
  localparam logic [OFF_W-1:0] CS0_HI = OFF_W'(CS0_BASE + BLK_SPAN);
  localparam logic [OFF_W-1:0] CS1_LO = OFF_W'(CS1_BASE);
  localparam logic [OFF_W-1:0] CS1_HI = OFF_W'(CS1_BASE + BLK_SPAN);

  localparam logic [HADDR_W-1:0] PAIR_LO = HADDR_W'(CS0_BASE / 2);
  localparam logic [HADDR_W-1:0] PAIR_HI = HADDR_W'(CS0_BASE / 2 + 1);

  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CS0 = 2'd1;
  localparam logic [1:0] SEL_CS1 = 2'd2;

  localparam logic [HALF_W-1:0] NO_DEV = '1;

  logic [OFF_W-1:0]  boff;
  logic              lane, acc16, hit_cfg, hit_cs0, hit_cs1, hit16;
  logic              pair_lo, pair_hi, rd_take;
  logic [HALF_W-1:0] hold_q, rd_next;

  assign boff    = {h_addr, 1'b0};
  assign lane    = h_addr[0];
  assign acc16   = h_req & ~h_win32;
  assign hit_cfg = (boff >= CFG_LO) && (boff < CFG_HI);
  assign hit_cs0 = (boff >= CS0_LO) && (boff < CS0_HI);
  assign hit_cs1 = (boff >= CS1_LO) && (boff < CS1_HI);
  assign hit16   = acc16 & (hit_cfg | hit_cs0 | hit_cs1);

  assign pair_lo = h_req & h_win32 & ~h_we & (h_addr == PAIR_LO);
  assign pair_hi = h_req & h_win32 & ~h_we & (h_addr == PAIR_HI);
  assign rd_take = h_req & ~h_we;

  assign d_stb = hit16 | pair_lo;
  assign d_we  = hit16 & h_we;
  assign d_sel = (hit16 & hit_cfg) ? SEL_CFG :
                 (hit16 & hit_cs1) ? SEL_CS1 : SEL_CS0;
  assign d_idx = pair_lo ? 2'd0 :
                 hit_cfg ? h_addr[2:1] : {1'b0, h_addr[1]};

  assign d_wdata = !d_we ? '0 :
                   lane  ? {h_wdata, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, h_wdata};
  assign d_be    = pair_lo ? '1 :
                   !hit16  ? '0 :
                   lane    ? {h_be, {HBE_W{1'b0}}} : {{HBE_W{1'b0}}, h_be};

  always_comb begin
    if (pair_lo)
      rd_next = d_rdata[HALF_W-1:0];
    else if (pair_hi)
      rd_next = hold_q;
    else if (hit16)
      rd_next = lane ? d_rdata[WORD_W-1:HALF_W] : d_rdata[HALF_W-1:0];
    else
      rd_next = NO_DEV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      hold_q   <= '0;
    end else begin
      h_rvalid <= rd_take;
      if (rd_take) h_rdata <= rd_next;
      if (pair_lo) hold_q <= d_rdata[WORD_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/ide_halfword_bridge_chk.sv
module ide_halfword_bridge_chk #(
  parameter int HADDR_W  = 11,
  parameter int HALF_W   = 16,
  parameter int CFG_BASE = 'h030,
  parameter int CFG_SPAN = 'h10,
  parameter int CS0_BASE = 'h1F0,
  parameter int CS1_BASE = 'h3F0,
  parameter int BLK_SPAN = 'h8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                h_req,
  input logic                h_win32,
  input logic                h_we,
  input logic [HADDR_W-1:0]  h_addr,
  input logic                h_rvalid,
  input logic [HALF_W-1:0]   h_rdata,
  input logic                d_stb,
  input logic [2*HALF_W-1:0] d_wdata,
  input logic [HALF_W/4-1:0] d_be,
  input logic [2*HALF_W-1:0] d_rdata,
  input logic [HALF_W-1:0]   hold_q
);
  localparam int OFF_W = HADDR_W + 1;
  localparam int HBE_W = HALF_W / 8;

  logic [OFF_W-1:0] off;
  logic mapped, rd_lo32, rd_hi32;

  assign off = {h_addr, 1'b0};
  assign mapped = (off >= OFF_W'(CFG_BASE) && off < OFF_W'(CFG_BASE + CFG_SPAN)) ||
                  (off >= OFF_W'(CS0_BASE) && off < OFF_W'(CS0_BASE + BLK_SPAN)) ||
                  (off >= OFF_W'(CS1_BASE) && off < OFF_W'(CS1_BASE + BLK_SPAN));
  assign rd_lo32 = h_req && h_win32 && !h_we && (h_addr == HADDR_W'(CS0_BASE / 2));
  assign rd_hi32 = h_req && h_win32 && !h_we && (h_addr == HADDR_W'(CS0_BASE / 2 + 1));

  assert_strobe_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    d_stb |-> h_req);
  assert_read_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we) |=> h_rvalid);
  assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_we) |=> !h_rvalid);
  assert_wide_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_we && h_win32) |-> !d_stb);
  assert_unmapped_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_win32 && !mapped) |-> !d_stb);
  assert_upper_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_stb && !h_win32 && h_addr[0]) |-> (d_be[HBE_W-1:0] == '0 && d_wdata[HALF_W-1:0] == '0));
  assert_latch_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo32 |=> hold_q == $past(d_rdata[2*HALF_W-1:HALF_W]));
  assert_latch_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi32 |=> h_rdata == $past(hold_q));
  assert_latch_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi32 |-> !d_stb);
  assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo32 |=> $stable(hold_q));
endmodule

bind ide_halfword_bridge ide_halfword_bridge_chk #(
  .HADDR_W(HADDR_W), .HALF_W(HALF_W), .CFG_BASE(CFG_BASE), .CFG_SPAN(CFG_SPAN),
  .CS0_BASE(CS0_BASE), .CS1_BASE(CS1_BASE), .BLK_SPAN(BLK_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_win32(h_win32), .h_we(h_we),
  .h_addr(h_addr), .h_rvalid(h_rvalid), .h_rdata(h_rdata), .d_stb(d_stb),
  .d_wdata(d_wdata), .d_be(d_be), .d_rdata(d_rdata), .hold_q(hold_q)
);

// File: tb/ide_halfword_bridge_test.sv
module ide_halfword_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_win32 = 1'b0, h_we = 1'b0;
  logic [10:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [1:0]  h_be = '0;
  logic        h_rvalid, d_stb, d_we;
  logic [15:0] h_rdata;
  logic [1:0]  d_sel, d_idx;
  logic [31:0] d_wdata, d_rdata;
  logic [3:0]  d_be;
  logic [11:0] salt = 12'h000;

  int vectors = 0;
  int miscompares = 0;

  function automatic logic [31:0] model(logic [1:0] s, logic [1:0] i, logic [11:0] k);
    return {s, i, k ^ 12'hA5C, s, i, k ^ 12'h3E1};
  endfunction

  assign d_rdata = model(d_sel, d_idx, salt);

  always #(CLK_PERIOD / 2) clk = ~clk;

  ide_halfword_bridge uut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_win32(h_win32), .h_we(h_we),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .d_stb(d_stb), .d_we(d_we), .d_sel(d_sel), .d_idx(d_idx),
    .d_wdata(d_wdata), .d_be(d_be), .d_rdata(d_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [10:0] addr;
    logic [15:0] wd;
    logic [1:0]  be;
    logic        stb;
    logic [1:0]  sel;
    logic [1:0]  idx;
    logic        ones;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 11'h018, 16'h0000, 2'b11, 1'b1, 2'd0, 2'd0, 1'b0},
    '{1'b0, 11'h01F, 16'h0000, 2'b11, 1'b1, 2'd0, 2'd3, 1'b0},
    '{1'b0, 11'h01C, 16'h0000, 2'b01, 1'b1, 2'd0, 2'd2, 1'b0},
    '{1'b1, 11'h01B, 16'h1234, 2'b11, 1'b1, 2'd0, 2'd1, 1'b0},
    '{1'b0, 11'h017, 16'h0000, 2'b11, 1'b0, 2'd0, 2'd0, 1'b1},
    '{1'b0, 11'h020, 16'h0000, 2'b11, 1'b0, 2'd0, 2'd0, 1'b1},
    '{1'b0, 11'h0F8, 16'h0000, 2'b11, 1'b1, 2'd1, 2'd0, 1'b0},
    '{1'b1, 11'h0FA, 16'hBEEF, 2'b01, 1'b1, 2'd1, 2'd1, 1'b0},
    '{1'b0, 11'h0FB, 16'h0000, 2'b10, 1'b1, 2'd1, 2'd1, 1'b0},
    '{1'b0, 11'h0FC, 16'h0000, 2'b11, 1'b0, 2'd0, 2'd0, 1'b1},
    '{1'b1, 11'h0F7, 16'h5555, 2'b11, 1'b0, 2'd0, 2'd0, 1'b0},
    '{1'b0, 11'h1F8, 16'h0000, 2'b11, 1'b1, 2'd2, 2'd0, 1'b0},
    '{1'b1, 11'h1F9, 16'h00A5, 2'b10, 1'b1, 2'd2, 2'd0, 1'b0},
    '{1'b0, 11'h1FB, 16'h0000, 2'b11, 1'b1, 2'd2, 2'd1, 1'b0},
    '{1'b0, 11'h1FC, 16'h0000, 2'b11, 1'b0, 2'd0, 2'd0, 1'b1},
    '{1'b1, 11'h1FC, 16'h7777, 2'b11, 1'b0, 2'd0, 2'd0, 1'b0},
    '{1'b0, 11'h7FF, 16'h0000, 2'b11, 1'b0, 2'd0, 2'd0, 1'b1}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  logic        s_stb, s_we, s_rv;
  logic [1:0]  s_sel, s_idx;
  logic [31:0] s_wd;
  logic [3:0]  s_be;
  logic [15:0] s_rd;

  task automatic access(input logic w32, input logic we, input logic [10:0] a,
                        input logic [15:0] wd, input logic [1:0] be);
    @(negedge clk);
    h_req = 1'b1; h_win32 = w32; h_we = we; h_addr = a; h_wdata = wd; h_be = be;
    #1;
    s_stb = d_stb; s_we = d_we; s_sel = d_sel; s_idx = d_idx; s_wd = d_wdata; s_be = d_be;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
    s_rv = h_rvalid; s_rd = h_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    vectors++;
    miscompares++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset rvalid", {31'd0, h_rvalid}, 32'd0);
    check("R9", "reset rdata", {16'd0, h_rdata}, 32'd0);
    rst_n = 1'b1;

    // R8: latch is zero straight after reset
    access(1'b1, 1'b0, 11'h0F9, 16'h0, 2'b11);
    check("R8", "reset latch", {16'd0, s_rd}, 32'd0);
    check("R6", "latch read no strobe", {31'd0, s_stb}, 32'd0);

    // Table walk over the 16-bit window: R1 R2 R3 R4 R9
    salt = 12'h2C4;
    for (int v = 0; v < NVEC; v++) begin
      access(1'b0, VECS[v].we, VECS[v].addr, VECS[v].wd, VECS[v].be);
      check(VECS[v].stb ? "R1" : "R4", "strobe", {31'd0, s_stb}, {31'd0, VECS[v].stb});
      if (VECS[v].stb) begin
        check("R1", "window select", {30'd0, s_sel}, {30'd0, VECS[v].sel});
        check("R3", "word index", {30'd0, s_idx}, {30'd0, VECS[v].idx});
        check("R1", "write flag", {31'd0, s_we}, {31'd0, VECS[v].we});
        check("R2", "byte mask lane",
              {28'd0, s_be}, {28'd0, VECS[v].addr[0] ? {VECS[v].be, 2'b00} : {2'b00, VECS[v].be}});
        if (VECS[v].we)
          check("R2", "write data lane", s_wd,
                VECS[v].addr[0] ? {VECS[v].wd, 16'h0} : {16'h0, VECS[v].wd});
      end
      check("R9", "rvalid", {31'd0, s_rv}, {31'd0, !VECS[v].we});
      if (!VECS[v].we) begin
        if (VECS[v].ones)
          check("R4", "unmapped read", {16'd0, s_rd}, 32'h0000FFFF);
        else
          check("R2", "read lane", {16'd0, s_rd},
                VECS[v].addr[0] ? {16'd0, model(VECS[v].sel, VECS[v].idx, salt) >> 16}
                                : {16'd0, model(VECS[v].sel, VECS[v].idx, salt) & 32'hFFFF});
      end
    end

    // R5: split data read, first half
    salt = 12'h123;
    access(1'b1, 1'b0, 11'h0F8, 16'h0, 2'b00);
    check("R5", "strobe", {31'd0, s_stb}, 32'd1);
    check("R5", "select", {30'd0, s_sel}, 32'd1);
    check("R5", "index", {30'd0, s_idx}, 32'd0);
    check("R5", "read flag", {31'd0, s_we}, 32'd0);
    check("R5", "full mask", {28'd0, s_be}, 32'hF);
    check("R5", "low half", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h123) & 32'hFFFF);

    // R6: second half from the latch, downstream data changed meanwhile
    salt = 12'h456;
    access(1'b1, 1'b0, 11'h0F9, 16'h0, 2'b00);
    check("R6", "no strobe", {31'd0, s_stb}, 32'd0);
    check("R6", "high half", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h123) >> 16);

    // R7: writes in the 32-bit window vanish
    access(1'b1, 1'b1, 11'h0F8, 16'hDEAD, 2'b11);
    check("R7", "write no strobe", {31'd0, s_stb}, 32'd0);
    check("R7", "write no rvalid", {31'd0, s_rv}, 32'd0);
    access(1'b1, 1'b1, 11'h0F9, 16'hCAFE, 2'b11);
    check("R7", "write no strobe", {31'd0, s_stb}, 32'd0);

    // R8: a 16-bit data read does not disturb the latch
    access(1'b0, 1'b0, 11'h0F8, 16'h0, 2'b11);
    access(1'b1, 1'b0, 11'h0F9, 16'h0, 2'b00);
    check("R8", "latch held", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h123) >> 16);
    check("R7", "latch kept after writes", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h123) >> 16);

    // R6: other reads in the 32-bit window
    access(1'b1, 1'b0, 11'h0FA, 16'h0, 2'b11);
    check("R6", "other offset", {16'd0, s_rd}, 32'h0000FFFF);
    check("R6", "other no strobe", {31'd0, s_stb}, 32'd0);
    access(1'b1, 1'b0, 11'h018, 16'h0, 2'b11);
    check("R6", "config offset", {16'd0, s_rd}, 32'h0000FFFF);
    check("R6", "config no strobe", {31'd0, s_stb}, 32'd0);

    // R5/R8: a second capture replaces the latch
    access(1'b1, 1'b0, 11'h0F8, 16'h0, 2'b00);
    check("R5", "second low half", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h456) & 32'hFFFF);
    salt = 12'h789;
    access(1'b1, 1'b0, 11'h0F9, 16'h0, 2'b00);
    check("R8", "new high half", {16'd0, s_rd}, model(2'd1, 2'd0, 12'h456) >> 16);

    // R9: strobe lasts one cycle only
    @(negedge clk);
    check("R9", "idle no strobe", {31'd0, d_stb}, 32'd0);
    check("R9", "idle no rvalid", {31'd0, h_rvalid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule